// File: doc/BRIEF.md
# Dual Channel Programmable Counter Timer

This block is a register-mapped peripheral with two independent counter channels. Each channel has a control word, a reload value and a live count, all on a small word-addressed register bus. A channel counts up or down on every clock while it is enabled. It can be pinned to its reload value, and it can run as a one-shot or as a periodic timer that reloads itself at terminal count.

At terminal count a channel sets a sticky event flag. Software clears the flag by writing 1 to it. Reading the control word and writing the same value back therefore acknowledges the event and keeps every other setting. One registered, active-high interrupt line is the OR of the two flags, each masked by its channel's interrupt-enable bit.

A single write can start both channels in the same cycle. Control bits for capture, external output and pulse-width modes are stored and read back, but they do nothing.

Top module: `dual_tmr`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A channel counts only while its enable (control bit 7) is 1. With enable 0 and the load bit 0, the count holds its value. A control write takes effect from the next clock: the step on the edge of the write uses the old settings.
- R3: While control bit 5 (load) is 1, the count is set to the reload value on every clock and does not step.
- R4: With control bit 1 set to 1 the count decrements by 1 per clock. With bit 1 set to 0 it increments by 1.
- R5: With control bit 4 (auto-reload) set to 1, terminal count copies the reload value into the count and the channel stays enabled. Counting up from a reload value of 0 therefore wraps freely.
- R6: With auto-reload 0, terminal count clears the enable bit and the count stays at its terminal value.
- R7: Control bit 8 (event flag) is cleared only by a control write with bit 8 set to 1. All other bits 0..7 and 9 take the written value, so writing back a value just read acknowledges the event.
- R8: Terminal count is an enabled, non-loading clock on which the count is 0 while counting down, or all ones while counting up. On that clock bit 8 becomes 1.
- R9: `irq` is 1 on the clock after a channel has bit 8 and bit 6 (interrupt enable) both set, and 0 otherwise.
- R10: A control write with bit 10 set to 1, to either channel, sets the enable of both channels. Bit 10 reads back as the AND of the two enables.
- R11: If an event flag clear and a terminal count fall on the same clock, the flag stays 1. A control write decides the enable value over the one-shot self-clear.
- R12: Control bits 0, 2, 3 and 9 are stored and read back but do not change counting. Writes to a count register are ignored. Unmapped word offsets read 0.
- R13: Byte offsets: channel 0 control 0x00, reload 0x04, count 0x08; channel 1 control 0x10, reload 0x14, count 0x18. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered, active-high combined interrupt |

## Verification
The risky coincidence is a software acknowledge that lands on the very clock the counter reaches terminal count. Done carelessly, the clear erases the new event. The bench provokes it by running channel 0 as a periodic down-counter and watching its own model until the count sits at 0 with the flag already set. On that clock it writes the control word back with bit 8 set, and it expects the flag to read 1 afterwards. A second write-back one cycle later must then clear the flag.

// File: rtl/dual_tmr.sv
module dual_tmr #(
  parameter int CW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int DOWN = 1, RELOAD = 4, LD = 5, IE = 6, EN = 7, FLAG = 8, PWM = 9, ALL = 10;
  localparam int IW = AW - 2;

  logic [IW-1:0] widx;
  logic [9:0]    ctl [2];
  logic [CW-1:0] ldv [2];
  logic [CW-1:0] cnt [2];
  logic [1:0]    term, csr_wr, ld_wr;
  logic          wall;

  assign widx = bus_addr[AW-1:2];
  assign wall = (|csr_wr) && bus_wdata[ALL];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      csr_wr[i] = bus_we && (widx == IW'(4*i));
      ld_wr[i]  = bus_we && (widx == IW'(4*i+1));
      term[i]   = ctl[i][EN] && !ctl[i][LD] &&
                  (ctl[i][DOWN] ? (cnt[i] == '0) : (cnt[i] == '1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        ctl[i] <= '0;
        ldv[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      irq <= (ctl[0][FLAG] & ctl[0][IE]) | (ctl[1][FLAG] & ctl[1][IE]);
      for (int i = 0; i < 2; i++) begin
        if (ld_wr[i]) ldv[i] <= bus_wdata[CW-1:0];
        if (ctl[i][LD]) cnt[i] <= ldv[i];
        else if (term[i]) begin
          if (ctl[i][RELOAD]) cnt[i] <= ldv[i];
        end else if (ctl[i][EN])
          cnt[i] <= ctl[i][DOWN] ? cnt[i] - 1'b1 : cnt[i] + 1'b1;
        if (csr_wr[i])
          ctl[i] <= {bus_wdata[PWM], (ctl[i][FLAG] & ~bus_wdata[FLAG]) | term[i],
                     bus_wdata[EN] | bus_wdata[ALL], bus_wdata[6:0]};
        else begin
          if (term[i]) ctl[i][FLAG] <= 1'b1;
          if (term[i] && !ctl[i][RELOAD]) ctl[i][EN] <= 1'b0;
          if (wall) ctl[i][EN] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (widx)
      IW'(0):  bus_rdata = {21'b0, ctl[0][EN] & ctl[1][EN], ctl[0]};
      IW'(1):  bus_rdata = 32'(ldv[0]);
      IW'(2):  bus_rdata = 32'(cnt[0]);
      IW'(4):  bus_rdata = {21'b0, ctl[0][EN] & ctl[1][EN], ctl[1]};
      IW'(5):  bus_rdata = 32'(ldv[1]);
      IW'(6):  bus_rdata = 32'(cnt[1]);
      default: bus_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[g][EN] && !ctl[g][LD]) |=> $stable(cnt[g]));
    assert_load_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[g][LD] |=> (cnt[g] == $past(ldv[g])));
    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (term[g] && !ctl[g][RELOAD] && !csr_wr[g] && !wall) |=> !ctl[g][EN]);
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[g][FLAG] && !(csr_wr[g] && bus_wdata[FLAG])) |=> ctl[g][FLAG]);
    assert_term_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      term[g] |=> ctl[g][FLAG]);
  end

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !((ctl[0][FLAG] & ctl[0][IE]) | (ctl[1][FLAG] & ctl[1][IE])) |=> !irq);
endmodule

// File: tb/dual_tmr_tb.sv
module dual_tmr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wd = '0;
  logic [31:0] b_rd;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] last_rd;
  logic        last_irq;

  logic [9:0]  mc [2];
  logic [31:0] ml [2];
  logic [31:0] mn [2];
  logic        mirq;

  always #2 clk = ~clk;

  dual_tmr dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we),
                  .bus_wdata(b_wd), .bus_rdata(b_rd), .irq(irq_o));

  function automatic logic [31:0] mrd(logic [4:0] a);
    case (a[4:2])
      3'd0:    return {21'b0, mc[0][7] & mc[1][7], mc[0]};
      3'd1:    return ml[0];
      3'd2:    return mn[0];
      3'd4:    return {21'b0, mc[0][7] & mc[1][7], mc[1]};
      3'd5:    return ml[1];
      3'd6:    return mn[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(bit we, logic [4:0] a, logic [31:0] d);
    logic [9:0]  nc [2];
    logic [31:0] nl [2];
    logic [31:0] nn [2];
    bit t, wall;
    wall = we && d[10] && (a[4:2] == 3'd0 || a[4:2] == 3'd4);
    for (int c = 0; c < 2; c++) begin
      t = mc[c][7] && !mc[c][5] && (mc[c][1] ? mn[c] == 0 : mn[c] == 32'hFFFF_FFFF);
      nl[c] = (we && a[4:2] == 3'(4*c+1)) ? d : ml[c];
      if (mc[c][5]) nn[c] = ml[c];
      else if (t) nn[c] = mc[c][4] ? ml[c] : mn[c];
      else if (mc[c][7]) nn[c] = mc[c][1] ? mn[c] - 1 : mn[c] + 1;
      else nn[c] = mn[c];
      if (we && a[4:2] == 3'(4*c))
        nc[c] = {d[9], (mc[c][8] & ~d[8]) | t, d[7] | d[10], d[6:0]};
      else begin
        nc[c] = mc[c];
        if (t) nc[c][8] = 1'b1;
        if (t && !mc[c][4]) nc[c][7] = 1'b0;
        if (wall) nc[c][7] = 1'b1;
      end
    end
    mirq = (mc[0][8] & mc[0][6]) | (mc[1][8] & mc[1][6]);
    for (int c = 0; c < 2; c++) begin
      mc[c] = nc[c]; ml[c] = nl[c]; mn[c] = nn[c];
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(bit we, logic [4:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    b_we = we; b_addr = a; b_wd = d;
    #1;
    last_rd = b_rd;
    last_irq = irq_o;
    check(tag, b_rd, mrd(a));
    check({tag, " irq"}, {31'b0, irq_o}, {31'b0, mirq});
    @(posedge clk);
    step(we, a, d);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
    tick(1'b1, a, d, tag);
  endtask

  task automatic rd(logic [4:0] a, string tag);
    tick(1'b0, a, 32'h0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [4:0]  ra;
    logic [31:0] rdv;
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      mc[c] = '0; ml[c] = '0; mn[c] = '0;
    end
    mirq = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1, R13: reset values at every mapped offset
    foreach (v[i]) if (i < 7) begin
      rd(5'(i * 4), "R1");
      check("R1", last_rd, 32'h0);
    end
    check("R1 irq", {31'b0, last_irq}, 32'h0);

    // R3: load bit pins count
    wr(5'h04, 32'd5, "R13");
    wr(5'h00, 32'h0A2, "R3");
    repeat (4) rd(5'h08, "R3");
    check("R3", last_rd, 32'd5);

    // R4, R8, R6, R9: one-shot down count with interrupt
    wr(5'h00, 32'h0C2, "R4");
    rd(5'h08, "R4");
    rd(5'h08, "R4");
    check("R4", last_rd, 32'd4);
    for (int k = 0; k < 20; k++) begin
      rd(5'h00, "R8");
      if (last_rd[8]) break;
    end
    check("R8", {31'b0, last_rd[8]}, 32'd1);
    check("R6", {31'b0, last_rd[7]}, 32'd0);
    rd(5'h08, "R6");
    check("R6", last_rd, 32'd0);
    check("R9", {31'b0, last_irq}, 32'd1);

    // R7: write-back acknowledge
    rd(5'h00, "R7");
    v = last_rd;
    wr(5'h00, v, "R7");
    rd(5'h00, "R7");
    check("R7", last_rd, v & ~32'h100);
    rd(5'h00, "R9");
    check("R9", {31'b0, last_irq}, 32'd0);

    // R5: periodic up count near the top
    wr(5'h14, 32'hFFFF_FFFD, "R5");
    wr(5'h10, 32'h020, "R5");
    wr(5'h10, 32'h090, "R5");
    repeat (10) rd(5'h18, "R5");
    check("R5", {31'b0, last_rd >= 32'hFFFF_FFFD}, 32'd1);
    rd(5'h10, "R5");
    check("R5", last_rd & 32'h180, 32'h180);
    check("R9", {31'b0, last_irq}, 32'd0);

    // R2: disabling holds the count
    wr(5'h10, 32'h010, "R2");
    rd(5'h18, "R2");
    v = last_rd;
    repeat (5) rd(5'h10, "R2");
    rd(5'h18, "R2");
    check("R2", last_rd, v);

    // R10: enable-all
    wr(5'h00, 32'h400, "R10");
    rd(5'h00, "R10");
    check("R10", last_rd & 32'h480, 32'h480);
    rd(5'h10, "R10");
    check("R10", last_rd & 32'h080, 32'h080);

    // R11: acknowledge collides with terminal count
    wr(5'h04, 32'd3, "R11");
    wr(5'h00, 32'h020, "R11");
    wr(5'h00, 32'h0D2, "R11");
    for (int k = 0; k < 20 && !mc[0][8]; k++) rd(5'h08, "R11");
    rd(5'h08, "R11");
    for (int k = 0; k < 20 && !(mn[0] == 0 && mc[0][7] && !mc[0][5]); k++) rd(5'h08, "R11");
    wr(5'h00, 32'h1D2, "R11");
    rd(5'h00, "R11");
    check("R11", {31'b0, last_rd[8]}, 32'd1);
    wr(5'h00, 32'h1D2, "R7");
    rd(5'h00, "R7");
    check("R7", {31'b0, last_rd[8]}, 32'd0);

    // R12: inert bits, count writes, unmapped offset
    wr(5'h08, 32'h1234, "R12");
    rd(5'h08, "R12");
    wr(5'h04, 32'd10, "R12");
    wr(5'h00, 32'h020, "R12");
    wr(5'h00, 32'h28F, "R12");
    rd(5'h00, "R12");
    check("R12", last_rd & 32'h20D, 32'h20D);
    rd(5'h08, "R12");
    check("R12", last_rd, 32'd9);
    rd(5'h0C, "R12");
    check("R12", last_rd, 32'h0);

    // random mix, checked against the model
    for (int k = 0; k < 4000; k++) begin
      ra = {3'($urandom % 8), 2'($urandom % 4)};
      if (($urandom % 10) < 3) begin
        case ($urandom % 4)
          0: rdv = $urandom % 8;
          1: rdv = 32'hFFFF_FFFF - ($urandom % 8);
          default: rdv = $urandom;
        endcase
        if (ra[3:2] == 2'd0) begin
          rdv = rdv & 32'h7FF;
          if (($urandom % 4) != 0) rdv[5] = 1'b0;
          if (($urandom % 8) != 0) rdv[10] = 1'b0;
        end
        wr(ra, rdv, "R4 rnd");
      end else
        rd(ra, "R5 rnd");
    end
    finish_run();
  end
endmodule